// File: doc/BRIEF.md
# Pipelined Converter Correction Back End

This block is the digital tail of a ten-stage pipelined analog-to-digital converter. Every pipeline stage hands over a redundant three-level decision (minus one, zero or plus one). A given sample moves one stage forward each half conversion period, so its ten decisions reach the block at ten different half-cycle instants. The block delays each stage's decision so that all ten decisions of one sample meet at the same moment. It then adds them with binary weights that overlap by one bit, saturates the sum to the 10-bit range and loads it into the output word register.

The block runs on a clock at twice the conversion rate, so one clock tick is one half-cycle. The input `rise_ph` is high in those ticks whose closing edge is a rising edge of the conversion clock, and the output register loads only in those ticks. A sample taken at a falling conversion edge therefore shows up 11 ticks later, which is 5.5 conversion cycles, at a rising edge. The stage overlap makes the adder tolerant of comparator offsets: a stage that resolves the wrong level is corrected by the stages that follow it. The block also provides an output-enable control, a power-down input that freezes the output word, and a flag that marks the word valid once a full sample has passed through.

Top module: `pipecorr_backend`

## Requirements
- R1: Each stage decision is a 2-bit code: 2'b00 means -1, 2'b01 means 0 and 2'b10 means +1. The code 2'b11 is illegal. It contributes 0 to the sum, and `dec_err` is high for the output word in which it takes part.
- R2: Stage k (k = 1..10) occupies `dec[2k-1:2k-2]`. The output word is 512 + sum of d_k * 2^(10-k), in straight offset binary, with `dout[9]` as the MSB.
- R3: A sum below 0 gives code 0, and a sum above 1023 gives code 1023.
- R4: Stage k of a sample taken at tick s is presented during tick s+k. The word for that sample is on `dout` after the edge that closes tick s+10, which is 11 ticks after sampling.
- R5: The output word and `dec_err` change only at edges that close a tick with `rise_ph` high. Decisions presented out of phase never reach the output.
- R6: Decision sets that differ by a stage's redundancy (for example +1,-1 against 0,+1 in stages 1 and 2) produce the same code.
- R7: While `oe_n` is high, `dout_en` is low and `dout` reads 0. While `oe_n` is low, `dout_en` is high and `dout` shows the held word.
- R8: While `pd` is high, the output word and `dec_err` hold the value they had before power-down.
- R9: `out_valid` is low during reset and during power-down. After either ends, it rises at the sixth load edge and stays high.
- R10: A synchronous reset clears the deskew chains, the output word and `dec_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock at twice the conversion rate |
| rst | input | 1 | Synchronous reset, active high |
| rise_ph | input | 1 | High in ticks that end on a rising conversion edge |
| pd | input | 1 | Power-down: freezes the output word, clears validity |
| oe_n | input | 1 | Output enable, active low |
| dec | input | 20 | Ten 2-bit stage decisions, stage 1 in the low pair |
| dout | output | 10 | Corrected offset-binary word, 0 while disabled |
| dout_en | output | 1 | Output driver enable |
| out_valid | output | 1 | Word comes from a fully flushed sample |
| dec_err | output | 1 | The word's sample contained an illegal decision code |

## Verification
A deskew chain of the wrong depth for one stage pairs that stage's decision with a neighbouring sample. It appears as a wrong code on the very first streamed vector that exercises that stage, 11 ticks after the sample was taken. A load that is enabled in the wrong phase brings in the deliberately illegal codes that the bench drives in the off-phase slots. This shows up within one tick as a changed word or a raised error flag. A flush counter that is off by one moves the rise of `out_valid` by one load edge, and the bench checks both the edge before and the edge at the expected rise, after reset and again after power-down.

// File: rtl/pipecorr_backend.sv
`timescale 1ns/1ps
module pipecorr_backend #(
  parameter int STAGES = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rise_ph,
  input  logic                  pd,
  input  logic                  oe_n,
  input  logic [2*STAGES-1:0]   dec,
  output logic [STAGES-1:0]     dout,
  output logic                  dout_en,
  output logic                  out_valid,
  output logic                  dec_err
);
  localparam int OUT_W = STAGES;
  localparam int SW    = STAGES + 2;
  localparam int FLUSH = STAGES / 2 + 1;
  localparam int CW    = $clog2(FLUSH + 1);
  localparam logic signed [SW-1:0] MID  = SW'(1) << (STAGES - 1);
  localparam logic signed [SW-1:0] MAXC = (SW'(1) << OUT_W) - SW'(1);

  logic [1:0]            al [STAGES];
  logic signed [SW-1:0]  acc;
  logic                  illegal;
  logic [OUT_W-1:0]      code;
  logic [OUT_W-1:0]      word_q;
  logic                  err_q;
  logic [CW-1:0]         cnt_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_skew
    localparam int D = STAGES - 1 - g;
    if (D == 0) begin : g_direct
      assign al[g] = dec[2*g +: 2];
    end else begin : g_chain
      logic [1:0] sh [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int j = 0; j < D; j++) sh[j] <= 2'b00;
        end else begin
          sh[0] <= dec[2*g +: 2];
          for (int j = 1; j < D; j++) sh[j] <= sh[j-1];
        end
      end
      assign al[g] = sh[D-1];
    end
  end

  always_comb begin
    acc     = MID;
    illegal = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      case (al[i])
        2'b00:   acc = acc - (MID >>> i);
        2'b10:   acc = acc + (MID >>> i);
        2'b11:   illegal = 1'b1;
        default: ;
      endcase
    end
    if (acc < 0)         code = '0;
    else if (acc > MAXC) code = '1;
    else                 code = acc[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      err_q  <= 1'b0;
    end else if (rise_ph && !pd) begin
      word_q <= code;
      err_q  <= illegal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pd)                         cnt_q <= '0;
    else if (rise_ph && cnt_q != CW'(FLUSH)) cnt_q <= cnt_q + CW'(1);
  end

  assign out_valid = (cnt_q == CW'(FLUSH));
  assign dout_en   = !oe_n;
  assign dout      = oe_n ? '0 : word_q;
  assign dec_err   = err_q;
endmodule

module pipecorr_backend_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         rise_ph,
  input logic         pd,
  input logic [W-1:0] word,
  input logic         err,
  input logic         out_valid
);
  p_offphase_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rise_ph |=> ($stable(word) && $stable(err)));

  p_pd_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    pd |=> ($stable(word) && $stable(err)));

  p_pd_invalid_r9: assert property (@(posedge clk) disable iff (rst)
    pd |=> !out_valid);

  p_valid_on_load_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(rise_ph && !pd));

  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !pd) |=> out_valid);
endmodule

bind pipecorr_backend pipecorr_backend_chk #(.W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .rise_ph(rise_ph), .pd(pd),
  .word(word_q), .err(err_q), .out_valid(out_valid)
);

// File: tb/test_pipecorr_backend.sv
`timescale 1ns/1ps
module test_pipecorr_backend;
  localparam int S = 10;
  localparam int N = 16;
  localparam logic [2*S-1:0] ZEROS = 20'h55555;
  // d1..d10 (9 = illegal code), expected code, expected error flag
  localparam int VT [N][12] = '{
    '{ 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,  512, 0},
    '{ 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1023, 0},
    '{-1,-1,-1,-1,-1,-1,-1,-1,-1,-1,    0, 0},
    '{ 1,-1, 0, 0, 0, 0, 0, 0, 0, 0,  768, 0},
    '{ 0, 1, 0, 0, 0, 0, 0, 0, 0, 0,  768, 0},
    '{ 0, 0, 0, 0, 0, 0, 0, 0, 0,-1,  511, 0},
    '{ 0, 0, 0, 0, 0, 0, 0, 0, 0, 1,  513, 0},
    '{ 1, 0, 0, 0, 0, 0, 0, 0, 0,-1, 1023, 0},
    '{ 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1023, 0},
    '{-1, 0, 0, 0, 0, 0, 0, 0, 0, 0,    0, 0},
    '{-1, 0, 0, 0, 0, 0, 0, 0, 0, 1,    1, 0},
    '{ 0, 0, 1, 0,-1, 0, 1, 0, 0, 0,  616, 0},
    '{-1, 1, 1, 1, 0, 0, 0, 0, 0, 0,  448, 0},
    '{ 0, 0, 0, 0, 9, 0, 0, 0, 0, 0,  512, 1},
    '{ 1,-1,-1,-1,-1,-1,-1,-1,-1,-1,  513, 0},
    '{ 0,-1, 1, 1, 1, 1, 1, 1, 1, 1,  511, 0}
  };

  logic clk = 1'b0, rst = 1'b1, rise_ph = 1'b0, pd = 1'b0, oe_n = 1'b0;
  logic [2*S-1:0] dec = '1;
  logic [S-1:0] dout;
  logic dout_en, out_valid, dec_err;
  int checks = 0, fails = 0, t = 0;

  always #4 clk = ~clk;

  pipecorr_backend #(.STAGES(S)) i_pipecorr_backend (
    .clk(clk), .rst(rst), .rise_ph(rise_ph), .pd(pd), .oe_n(oe_n),
    .dec(dec), .dout(dout), .dout_en(dout_en),
    .out_valid(out_valid), .dec_err(dec_err)
  );

  function automatic logic [1:0] enc(input int d);
    case (d)
      -1:      return 2'b00;
      0:       return 2'b01;
      1:       return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [2*S-1:0] stream_word(input int tk);
    logic [2*S-1:0] w;
    for (int k = 1; k <= S; k++) begin
      int s;
      s = tk - k;
      if (s >= 0 && s % 2 == 0 && s / 2 < N) w[2*k-2 +: 2] = enc(VT[s/2][k-1]);
      else if (s >= 0 && s % 2 == 1)         w[2*k-2 +: 2] = 2'b11;
      else                                   w[2*k-2 +: 2] = 2'b01;
    end
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [2*S-1:0] w);
    dec = w;
    rise_ph = (t % 2 == 0);
    @(posedge clk);
    @(negedge clk);
    t++;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual %0d expected %0d", t, -1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int prev;
    int loads;
    repeat (3) @(negedge clk);
    check("R10 reset word", dout, 0);
    check("R10 reset err", dec_err, 0);
    check("R9 reset valid", out_valid, 0);
    check("R7 enabled", dout_en, 1);

    rst = 1'b0;
    t = 0;
    prev = 0;
    for (int tk = 0; tk < 2*N + 10; tk++) begin
      step(stream_word(tk));
      if (tk == 8)  check("R9 fifth load not valid", out_valid, 0);
      if (tk == 10) check("R9 sixth load valid", out_valid, 1);
      if (tk % 2 == 0 && tk >= 10 && (tk - 10) / 2 < N) begin
        int idx;
        idx = (tk - 10) / 2;
        check($sformatf("R2 R3 R4 R6 vec%0d code", idx), dout, VT[idx][10]);
        check($sformatf("R1 vec%0d err", idx), dec_err, VT[idx][11]);
      end else if (tk % 2 == 1) begin
        check("R5 off-phase hold", dout, prev);
      end
      prev = dout;
    end

    pd = 1'b1;
    repeat (20) step(ZEROS);
    check("R8 frozen word", dout, VT[N-1][10]);
    check("R8 frozen err", dec_err, 0);
    check("R9 pd invalid", out_valid, 0);

    oe_n = 1'b1;
    step(ZEROS);
    check("R7 disabled en", dout_en, 0);
    check("R7 disabled data", dout, 0);
    oe_n = 1'b0;
    step(ZEROS);
    check("R7 re-enabled en", dout_en, 1);
    check("R7 R8 re-enabled data", dout, VT[N-1][10]);

    pd = 1'b0;
    loads = 0;
    for (int i = 0; i < 14; i++) begin
      bit ev;
      ev = (t % 2 == 0);
      step(ZEROS);
      if (ev) begin
        loads++;
        check($sformatf("R9 valid after %0d loads", loads), out_valid, (loads >= 6) ? 1 : 0);
        check("R2 word after wake", dout, 512);
      end
    end

    rst = 1'b1;
    step(ZEROS);
    check("R10 mid reset word", dout, 0);
    check("R10 mid reset valid", out_valid, 0);
    check("R10 mid reset err", dec_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule